// File: doc/BRIEF.md
# Sliding Window Energy Engine

This block streams a greyscale image in raster order and, for every placement of a square window that lies wholly inside the frame, returns the exact sum of the squared pixel values under that window. The result is the energy term that a template matcher needs for the denominator of a normalized cross-correlation. All arithmetic is unsigned integer, so each result is exact.

Pixels enter on a valid/ready stream that marks the first pixel of a frame and the last pixel of each row. Internally, one RAM per earlier row keeps enough history that a whole vertical column of the window is available as each pixel arrives. The squares of that column are summed, and a running horizontal total adds the newest column sum and removes the one that has just left the window. Results leave on a valid/ready stream tagged with the window's top-left column and row. A stalled output holds the whole pipeline and the input.

Top module: `sqsum_window_energy`

## Requirements
- R1: While reset is high and in the cycle after it is released, `out_valid` is 0 and `in_ready` is 1.
- R2: Each result `out_energy` equals the sum, over the 8x8 window whose top-left pixel is at (`out_x`, `out_y`), of the square of each 16-bit unsigned pixel, exact in 38 bits.
- R3: A window made entirely of 0xFFFF pixels yields 64 * 0xFFFF^2 = 274869518400, the largest value, without wrap.
- R4: Each frame of IMG_W x IMG_H pixels yields exactly (IMG_W-7) x (IMG_H-7) results, one per window wholly inside the frame, in raster order: `out_x` runs 0..IMG_W-8 within a row of windows, then `out_y` steps by one.
- R5: `out_x` is the column and `out_y` the row (both counted from 0 at the frame's first pixel) of the window's top-left pixel.
- R6: A pixel accepted with `in_sof` = 1 is at column 0, row 0; a pixel accepted with `in_eol` = 1 is the last of its row. Rows of an earlier frame never contribute to a result of a later frame.
- R7: While `out_valid` = 1 and `out_ready` = 0, the result and its coordinates stay unchanged and `in_ready` is 0; no result is lost or repeated.
- R8: Cycles with `in_valid` = 0 change nothing; the results depend only on the accepted pixels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Pixel present |
| in_ready | output | 1 | Pixel accepted this cycle when also valid |
| in_pixel | input | PIX_W (16) | Unsigned greyscale value |
| in_sof | input | 1 | First pixel of a frame |
| in_eol | input | 1 | Last pixel of a row |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result |
| out_energy | output | SUM_W (38) | Sum of squares over the window |
| out_x | output | X_W (10) | Window top-left column |
| out_y | output | Y_W (10) | Window top-left row |

## Verification
The hardest situation to reach is a result held under backpressure at the same moment that a line-buffer write and a new read are pending, because a stall there must freeze the RAM outputs and the running total together. The stimulus reaches it by combining random gaps on the input with random refusals on the output over whole frames, so stalls fall at row starts, row ends and the first full rows. A frame of all-maximum pixels followed by a random frame checks both the top of the range and that stale rows from the earlier frame never leak into the new frame's results.

// File: rtl/sqsum_pkg.sv
package sqsum_pkg;
  // Width of one squared pixel
  function automatic int sq_width(input int pix_w);
    return 2 * pix_w;
  endfunction

  // Width of a sum of n squared pixels
  function automatic int acc_width(input int pix_w, input int n);
    return 2 * pix_w + $clog2(n);
  endfunction
endpackage

// File: rtl/sqsum_linebuf.sv
module sqsum_linebuf #(
  parameter int DEPTH = 1024,
  parameter int DW    = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/sqsum_colsq.sv
module sqsum_colsq
  import sqsum_pkg::*;
#(
  parameter int PIX_W = 16,
  parameter int WIN   = 8,
  parameter int TAG_W = 20,
  localparam int SQ_W  = sq_width(PIX_W),
  localparam int COL_W = acc_width(PIX_W, WIN)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 adv,
  input  logic                 in_valid,
  input  logic [WIN*PIX_W-1:0] in_col,
  input  logic [TAG_W-1:0]     in_tag,
  output logic                 out_valid,
  output logic [COL_W-1:0]     out_sum,
  output logic [TAG_W-1:0]     out_tag
);
  logic [SQ_W-1:0]  sq_q [WIN];
  logic             sq_valid;
  logic [TAG_W-1:0] sq_tag;
  logic [COL_W-1:0] col_acc;

  // Stage A: square each pixel of the column
  always_ff @(posedge clk) begin
    if (adv) begin
      for (int k = 0; k < WIN; k++) begin
        sq_q[k] <= SQ_W'(in_col[k*PIX_W +: PIX_W]) * SQ_W'(in_col[k*PIX_W +: PIX_W]);
      end
      sq_tag <= in_tag;
    end
  end

  // Stage B: add the column
  always_comb begin
    col_acc = '0;
    for (int k = 0; k < WIN; k++) col_acc = col_acc + COL_W'(sq_q[k]);
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      out_sum <= col_acc;
      out_tag <= sq_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sq_valid  <= 1'b0;
      out_valid <= 1'b0;
    end else if (adv) begin
      sq_valid  <= in_valid;
      out_valid <= sq_valid;
    end
  end

  localparam logic [COL_W-1:0] PMAX    = COL_W'({PIX_W{1'b1}});
  localparam logic [COL_W-1:0] COL_MAX = PMAX * PMAX * COL_W'(WIN);

  AST_COL_BOUND: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_sum <= COL_MAX); // R2
endmodule

// File: rtl/sqsum_runsum.sv
module sqsum_runsum
  import sqsum_pkg::*;
#(
  parameter int PIX_W = 16,
  parameter int WIN   = 8,
  parameter int X_W   = 10,
  parameter int Y_W   = 10,
  localparam int COL_W = acc_width(PIX_W, WIN),
  localparam int SUM_W = acc_width(PIX_W, WIN * WIN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic             in_valid,
  input  logic [COL_W-1:0] in_col,
  input  logic [X_W-1:0]   in_x,
  input  logic [Y_W-1:0]   in_y,
  output logic             out_valid,
  output logic [SUM_W-1:0] out_energy,
  output logic [X_W-1:0]   out_x,
  output logic [Y_W-1:0]   out_y
);
  logic [COL_W-1:0] hist [WIN];
  logic [SUM_W-1:0] run_q;
  logic [SUM_W-1:0] run_nxt;
  logic             full_win;

  always_comb begin
    run_nxt = (in_x == '0) ? '0 : run_q;
    run_nxt = run_nxt + SUM_W'(in_col);
    if (in_x >= X_W'(WIN)) run_nxt = run_nxt - SUM_W'(hist[WIN-1]);
    full_win = (in_x >= X_W'(WIN-1)) && (in_y >= Y_W'(WIN-1));
  end

  always_ff @(posedge clk) begin
    if (adv && in_valid) begin
      hist[0] <= in_col;
      for (int k = 1; k < WIN; k++) hist[k] <= hist[k-1];
      run_q <= run_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (adv) begin
      out_valid <= in_valid && full_win;
    end
  end

  always_ff @(posedge clk) begin
    if (adv && in_valid && full_win) begin
      out_energy <= run_nxt;
      out_x      <= in_x - X_W'(WIN-1);
      out_y      <= in_y - Y_W'(WIN-1);
    end
  end

  localparam logic [SUM_W-1:0] PMAX  = SUM_W'({PIX_W{1'b1}});
  localparam logic [SUM_W-1:0] E_MAX = PMAX * PMAX * SUM_W'(WIN * WIN);

  AST_ENERGY_BOUND: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_energy <= E_MAX); // R3
endmodule

// File: rtl/sqsum_window_energy.sv
module sqsum_window_energy
  import sqsum_pkg::*;
#(
  parameter int IMG_W = 1024,
  parameter int IMG_H = 768,
  parameter int PIX_W = 16,
  parameter int WIN   = 8,
  localparam int X_W   = $clog2(IMG_W),
  localparam int Y_W   = $clog2(IMG_H),
  localparam int COL_W = acc_width(PIX_W, WIN),
  localparam int SUM_W = acc_width(PIX_W, WIN * WIN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_pixel,
  input  logic             in_sof,
  input  logic             in_eol,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [SUM_W-1:0] out_energy,
  output logic [X_W-1:0]   out_x,
  output logic [Y_W-1:0]   out_y
);
  localparam int NBUF  = WIN - 1;
  localparam int TAG_W = X_W + Y_W;

  logic             adv;
  logic             in_fire;
  logic [X_W-1:0]   cnt_x, pos_x;
  logic [Y_W-1:0]   cnt_y, pos_y;

  logic             s1_valid;
  logic [PIX_W-1:0] s1_pix;
  logic [X_W-1:0]   s1_x;
  logic [Y_W-1:0]   s1_y;
  logic [PIX_W-1:0] rd_row [NBUF];
  logic [PIX_W-1:0] wr_row [NBUF];
  logic [WIN*PIX_W-1:0] column;

  logic             c_valid;
  logic [COL_W-1:0] c_sum;
  logic [TAG_W-1:0] c_tag;

  // The whole pipeline moves only when the output register can take a result
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;
  assign in_fire  = in_valid && adv;

  // Position of the pixel on the input
  assign pos_x = in_sof ? '0 : cnt_x;
  assign pos_y = in_sof ? '0 : cnt_y;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_x <= '0;
      cnt_y <= '0;
    end else if (in_fire) begin
      if (in_eol) begin
        cnt_x <= '0;
        cnt_y <= pos_y + Y_W'(1);
      end else begin
        cnt_x <= pos_x + X_W'(1);
        cnt_y <= pos_y;
      end
    end
  end

  // Stage 1: pixel register beside the synchronous line-buffer reads
  always_ff @(posedge clk) begin
    if (rst) s1_valid <= 1'b0;
    else if (adv) s1_valid <= in_fire;
  end

  always_ff @(posedge clk) begin
    if (in_fire) begin
      s1_pix <= in_pixel;
      s1_x   <= pos_x;
      s1_y   <= pos_y;
    end
  end

  // Row k of the chain holds the row k+1 above the current one
  generate
    for (genvar k = 0; k < NBUF; k++) begin : g_row
      if (k == 0) begin : g_first
        assign wr_row[k] = s1_pix;
      end else begin : g_next
        assign wr_row[k] = rd_row[k-1];
      end

      sqsum_linebuf #(.DEPTH(IMG_W), .DW(PIX_W)) u_lb (
        .clk     (clk),
        .rd_en   (in_fire),
        .rd_addr (pos_x),
        .rd_data (rd_row[k]),
        .wr_en   (adv && s1_valid),
        .wr_addr (s1_x),
        .wr_data (wr_row[k])
      );

      assign column[(k+1)*PIX_W +: PIX_W] = rd_row[k];
    end
  endgenerate

  assign column[0 +: PIX_W] = s1_pix;

  sqsum_colsq #(.PIX_W(PIX_W), .WIN(WIN), .TAG_W(TAG_W)) u_colsq (
    .clk       (clk),
    .rst       (rst),
    .adv       (adv),
    .in_valid  (s1_valid),
    .in_col    (column),
    .in_tag    ({s1_y, s1_x}),
    .out_valid (c_valid),
    .out_sum   (c_sum),
    .out_tag   (c_tag)
  );

  sqsum_runsum #(.PIX_W(PIX_W), .WIN(WIN), .X_W(X_W), .Y_W(Y_W)) u_run (
    .clk        (clk),
    .rst        (rst),
    .adv        (adv),
    .in_valid   (c_valid),
    .in_col     (c_sum),
    .in_x       (c_tag[X_W-1:0]),
    .in_y       (c_tag[TAG_W-1:X_W]),
    .out_valid  (out_valid),
    .out_energy (out_energy),
    .out_x      (out_x),
    .out_y      (out_y)
  );

  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_energy)
      && $stable(out_x) && $stable(out_y)); // R7

  AST_BLOCK_INPUT: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready); // R7

  AST_EOL_AT_EDGE: assert property (@(posedge clk) disable iff (rst)
    in_fire && in_eol |-> pos_x == X_W'(IMG_W - 1)); // R6

  AST_COORD_RANGE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_x <= X_W'(IMG_W - WIN)) && (out_y <= Y_W'(IMG_H - WIN))); // R4

  AST_RESET_IDLE: assert property (@(posedge clk)
    $past(rst) |-> !out_valid); // R1
endmodule

// File: tb/sqsum_window_energy_bench.sv
module sqsum_window_energy_bench;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int W     = 16;
  localparam int H     = 12;
  localparam int WIN   = 8;
  localparam int PW    = 16;
  localparam int XW    = $clog2(W);
  localparam int YW    = $clog2(H);
  localparam int SW    = 38;
  localparam int NRES  = (W - WIN + 1) * (H - WIN + 1);

  logic          clk = 1'b0;
  logic          rst;
  logic          in_valid, in_ready, in_sof, in_eol;
  logic [PW-1:0] in_pixel;
  logic          out_valid, out_ready;
  logic [SW-1:0] out_energy;
  logic [XW-1:0] out_x;
  logic [YW-1:0] out_y;

  always #2.5 clk = ~clk;

  sqsum_window_energy #(.IMG_W(W), .IMG_H(H), .PIX_W(PW), .WIN(WIN)) u_sqsum_window_energy (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_pixel(in_pixel),
    .in_sof(in_sof), .in_eol(in_eol), .out_valid(out_valid), .out_ready(out_ready),
    .out_energy(out_energy), .out_x(out_x), .out_y(out_y)
  );

  typedef struct {
    int          x;
    int          y;
    logic [63:0] e;
  } exp_t;

  exp_t        sb[$];
  logic [PW-1:0] frame [H][W];
  int          checks = 0;
  int          errors = 0;
  int          recv   = 0;
  int          bp_pct = 0;
  string       e_tag  = "R2";
  bit          mon_on = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic fill(input int mode);
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++)
        frame[y][x] = (mode == 1) ? 16'hFFFF : PW'($urandom);
  endtask

  // Driver side of the scoreboard: push the expected windows in raster order
  task automatic push_expected();
    for (int y0 = 0; y0 <= H - WIN; y0++)
      for (int x0 = 0; x0 <= W - WIN; x0++) begin
        exp_t it;
        it.x = x0;
        it.y = y0;
        it.e = '0;
        for (int r = 0; r < WIN; r++)
          for (int c = 0; c < WIN; c++)
            it.e += 64'(frame[y0+r][x0+c]) * 64'(frame[y0+r][x0+c]);
        sb.push_back(it);
      end
  endtask

  task automatic drive_frame(input int gap_pct);
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++) begin
        do begin
          @(negedge clk);
          in_valid = ($urandom_range(99) >= gap_pct);
          in_pixel = in_valid ? frame[y][x] : PW'($urandom);
          in_sof   = (x == 0 && y == 0);
          in_eol   = (x == W - 1);
          #1;
        end while (!(in_valid && in_ready));
      end
    @(negedge clk);
    in_valid = 1'b0;
    in_sof   = 1'b0;
    in_eol   = 1'b0;
  endtask

  task automatic run_frame(input int mode, input int gap_pct, input int bpp, input string tag);
    fill(mode);
    e_tag  = tag;
    bp_pct = bpp;
    recv   = 0;
    push_expected();
    drive_frame(gap_pct);
    for (int i = 0; i < 2000 && sb.size() != 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
    check(recv == NRES, "R4", "results per frame", recv, NRES);
    check(sb.size() == 0, "R7", "results still owed", sb.size(), 0);
  endtask

  // Monitor side of the scoreboard
  logic [SW-1:0] held_e;
  logic [XW-1:0] held_x;
  logic [YW-1:0] held_y;
  bit            held = 1'b0;

  initial begin
    forever begin
      @(negedge clk);
      out_ready = (bp_pct == 0) ? 1'b1 : ($urandom_range(99) >= bp_pct);
      #1;
      if (mon_on) begin
        if (held) begin
          check(out_valid && out_energy == held_e && out_x == held_x && out_y == held_y,
                "R7", "held result changed", longint'(out_energy), longint'(held_e));
        end
        held = out_valid && !out_ready;
        if (held) begin
          held_e = out_energy;
          held_x = out_x;
          held_y = out_y;
          check(!in_ready, "R7", "in_ready while stalled", in_ready, 0);
        end
        if (out_valid && out_ready) begin
          if (sb.size() == 0) begin
            check(1'b0, "R4", "unexpected result", out_x, -1);
          end else begin
            exp_t it;
            it = sb.pop_front();
            recv++;
            check(out_x == XW'(it.x), "R5", "window column", out_x, it.x);
            check(out_y == YW'(it.y), "R5", "window row", out_y, it.y);
            check(64'(out_energy) == it.e, e_tag, "energy", longint'(out_energy), longint'(it.e));
          end
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    check(1'b0, "R4", "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst      = 1'b1;
    in_valid = 1'b0;
    in_pixel = '0;
    in_sof   = 1'b0;
    in_eol   = 1'b0;
    out_ready = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check(!out_valid, "R1", "out_valid in reset", out_valid, 0);
    check(in_ready, "R1", "in_ready in reset", in_ready, 1);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1;
    check(!out_valid, "R1", "out_valid after reset", out_valid, 0);
    check(in_ready, "R1", "in_ready after reset", in_ready, 1);
    mon_on = 1'b1;

    run_frame(0, 0, 0, "R2");    // plain random frame
    run_frame(1, 0, 0, "R3");    // all 0xFFFF
    run_frame(0, 30, 40, "R6");  // new frame after max rows; gaps (R8) and stalls (R7)
    run_frame(0, 50, 70, "R8");  // heavy gaps and heavy backpressure
    run_frame(1, 20, 50, "R3");  // maximum values under stalls

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule